// File: doc/BRIEF.md
# Accumulator ALU with Packed Status Flags

This block is the arithmetic and flag-update core of an 8-bit accumulator datapath. It is purely combinational. Each evaluation takes an operation code, the accumulator value A, a second operand M from memory or an immediate field, and the current packed status byte. It returns a result word and the new status byte.

Every operation rewrites only its own subset of the condition flags. The remaining status bits come back exactly as they went in. Signed overflow is judged from the signs of the two adder operands against the sign of the sum. Subtraction and compare share the adder by feeding it the inverted operand. Decimal correction and register writeback live elsewhere, so the decimal-mode bit is carried through untouched.

The surrounding sequencer presents the operands and then captures `result_o` and `status_o` in the same cycle. For compare and bit test, the result port simply echoes A, so writing it back changes nothing.

Top module: `acc_alu`

## Requirements
- R1: The status byte is packed as bit 7 N, bit 6 V, bit 5 constant one, bit 4 B, bit 3 D, bit 2 I, bit 1 Z, bit 0 C. On every operation the output bit 5 is 1 and the output bits 4..2 equal the input bits 4..2.
- R2: Op code 0 (add with carry) gives result = A + M + C (low 8 bits). C becomes the carry out of bit 7. V is set when A and M share a sign and the result sign differs, and is cleared otherwise. N and Z follow the result.
- R3: Op code 1 (subtract with borrow) gives result = A + ~M + C, where C=1 means no borrow is pending. C out is 1 when no borrow occurred. V follows the add rule applied to A and ~M. N and Z follow the result.
- R4: Op codes 2 (AND), 3 (OR) and 4 (XOR) combine A and M bitwise and update only N and Z. V and C keep their input values.
- R5: Op code 5 shifts A left: bit 7 goes to C and bit 0 is filled with zero. Op code 6 shifts A right: bit 0 goes to C, bit 7 is filled with zero, and N therefore ends up clear. Both update N and Z and keep V.
- R6: Op code 7 rotates A left through C (old C into bit 0, old bit 7 into C). Op code 8 rotates A right through C (old C into bit 7, old bit 0 into C). Both update N and Z and keep V.
- R7: Op code 9 increments A and op code 10 decrements A, both modulo 256 (0xFF+1 = 0x00, 0x00-1 = 0xFF). They update only N and Z.
- R8: Op code 11 (compare) returns A unchanged on the result port. It sets C when A >= M unsigned, takes N and Z from A - M, and keeps V.
- R9: Op code 12 (bit test) returns A unchanged. It sets Z when (A & M) is zero, copies M bit 7 into N and M bit 6 into V, and keeps C.
- R10: Op codes 13, 14 and 15 return A unchanged and return the input status with only bit 5 forced to 1.
- R11: For op codes 0 through 10, Z is 1 exactly when all result bits are zero, and N equals result bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0..12 defined, 13..15 pass-through) |
| a_i | input | WIDTH | Accumulator operand A |
| m_i | input | WIDTH | Memory or immediate operand M |
| status_i | input | 8 | Current packed status byte |
| result_o | output | WIDTH | Operation result |
| status_o | output | 8 | Updated packed status byte |

## Verification
The block has no internal state, so a decode error, a broken carry link or a wrong flag-update mask shows up on `result_o` or `status_o` in the same evaluation in which the faulty operation is selected.

Two kinds of fault need particular stimulus to become visible:
- A flag that is wrongly updated only becomes visible when the incoming status holds the opposite value. The stimulus therefore sweeps both polarities of every input flag.
- A fault in a high carry link only shows when a carry has to travel through it. The stimulus therefore includes ripple-through values such as 0xFF + 1 and borrow across zero.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD_C = 4'd0,
    OP_SUB_B = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_SHL   = 4'd5,
    OP_SHR   = 4'd6,
    OP_ROTL  = 4'd7,
    OP_ROTR  = 4'd8,
    OP_INC   = 4'd9,
    OP_DEC   = 4'd10,
    OP_CMP   = 4'd11,
    OP_TEST  = 4'd12
  } alu_op_e;

  // status bit positions; the sequencer decodes these
  localparam int SB_C   = 0;
  localparam int SB_Z   = 1;
  localparam int SB_I   = 2;
  localparam int SB_D   = 3;
  localparam int SB_B   = 4;
  localparam int SB_ONE = 5;
  localparam int SB_V   = 6;
  localparam int SB_N   = 7;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

  typedef enum logic [1:0] {
    SRC_ADD   = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_PASS  = 2'd2
  } src_e;

endpackage

// File: rtl/acc_adder.sv
module acc_adder
  import acc_alu_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  generate
    if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] carry;
      assign carry[0] = cin_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry[i];
        assign carry[i+1]   = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
      end
      assign cout_o = carry[WIDTH];

      // gate-level chain checked against word arithmetic
      always_comb begin
        assert_adder_sum_R2: assert ({cout_o, sum_o} ==
          ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i)))
          else $error("adder chain disagrees with word sum");
      end
    end else begin : g_flat
      logic [WIDTH:0] total;
      assign total  = {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i);
      assign sum_o  = total[MSB:0];
      assign cout_o = total[WIDTH];
    end
  endgenerate

  // signed overflow: like-signed operands, differently signed sum
  assign ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    res_o  = a_i;
    cout_o = cin_i;
    case (op_i)
      OP_AND:  res_o = a_i & m_i;
      OP_OR:   res_o = a_i | m_i;
      OP_XOR:  res_o = a_i ^ m_i;
      OP_SHL: begin
        res_o  = {a_i[MSB-1:0], 1'b0};
        cout_o = a_i[MSB];
      end
      OP_SHR: begin
        res_o  = {1'b0, a_i[MSB:1]};
        cout_o = a_i[0];
      end
      OP_ROTL: begin
        res_o  = {a_i[MSB-1:0], cin_i};
        cout_o = a_i[MSB];
      end
      OP_ROTR: begin
        res_o  = {cin_i, a_i[MSB:1]};
        cout_o = a_i[0];
      end
      default: begin
        res_o  = a_i;
        cout_o = cin_i;
      end
    endcase
  end

endmodule

// File: rtl/acc_flag_merge.sv
module acc_flag_merge
  import acc_alu_pkg::*;
(
  input  logic [7:0] status_i,
  input  flags_t     upd_i,
  input  flags_t     val_i,
  output logic [7:0] status_o
);

  always_comb begin
    status_o         = status_i;
    status_o[SB_ONE] = 1'b1;
    if (upd_i.n) status_o[SB_N] = val_i.n;
    if (upd_i.v) status_o[SB_V] = val_i.v;
    if (upd_i.z) status_o[SB_Z] = val_i.z;
    if (upd_i.c) status_o[SB_C] = val_i.c;
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic [7:0]       status_i,
  output logic [WIDTH-1:0] result_o,
  output logic [7:0]       status_o
);

  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ALL_ZERO = {WIDTH{1'b0}};

  logic [WIDTH-1:0] add_b;
  logic             add_cin;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             add_ovf;
  logic [WIDTH-1:0] lu_res;
  logic             lu_cout;
  src_e             res_sel;
  src_e             flg_sel;
  logic             is_test;
  flags_t           upd;
  flags_t           val;
  logic [WIDTH-1:0] flag_src;

  // operand steering and flag-update mask
  always_comb begin
    add_b   = m_i;
    add_cin = status_i[SB_C];
    res_sel = SRC_PASS;
    flg_sel = SRC_PASS;
    is_test = 1'b0;
    upd     = '0;
    case (op_i)
      OP_ADD_C, OP_SUB_B: begin
        add_b   = (op_i == OP_SUB_B) ? ~m_i : m_i;
        res_sel = SRC_ADD;
        flg_sel = SRC_ADD;
        upd.n = 1'b1; upd.v = 1'b1; upd.z = 1'b1; upd.c = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_sel = SRC_LOGIC;
        flg_sel = SRC_LOGIC;
        upd.n = 1'b1; upd.z = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
        res_sel = SRC_LOGIC;
        flg_sel = SRC_LOGIC;
        upd.n = 1'b1; upd.z = 1'b1; upd.c = 1'b1;
      end
      OP_INC, OP_DEC: begin
        add_b   = (op_i == OP_DEC) ? ALL_ONES : ALL_ZERO;
        add_cin = (op_i == OP_INC);
        res_sel = SRC_ADD;
        flg_sel = SRC_ADD;
        upd.n = 1'b1; upd.z = 1'b1;
      end
      OP_CMP: begin
        add_b   = ~m_i;
        add_cin = 1'b1;
        res_sel = SRC_PASS;
        flg_sel = SRC_ADD;
        upd.n = 1'b1; upd.z = 1'b1; upd.c = 1'b1;
      end
      OP_TEST: begin
        is_test = 1'b1;
        upd.n = 1'b1; upd.v = 1'b1; upd.z = 1'b1;
      end
      default: begin
        res_sel = SRC_PASS;
        flg_sel = SRC_PASS;
      end
    endcase
  end

  acc_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_adder (
    .a_i    (a_i),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  acc_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op_i   (op_i),
    .a_i    (a_i),
    .m_i    (m_i),
    .cin_i  (status_i[SB_C]),
    .res_o  (lu_res),
    .cout_o (lu_cout)
  );

  // result and flag-source multiplexers
  always_comb begin
    case (res_sel)
      SRC_ADD:   result_o = add_sum;
      SRC_LOGIC: result_o = lu_res;
      default:   result_o = a_i;
    endcase
    case (flg_sel)
      SRC_ADD:   flag_src = add_sum;
      SRC_LOGIC: flag_src = lu_res;
      default:   flag_src = a_i;
    endcase
  end

  always_comb begin
    val.n = is_test ? m_i[MSB]              : flag_src[MSB];
    val.v = is_test ? m_i[MSB-1]            : add_ovf;
    val.z = is_test ? ((a_i & m_i) == '0)   : (flag_src == '0);
    val.c = (flg_sel == SRC_LOGIC) ? lu_cout : add_cout;
  end

  acc_flag_merge u_merge (
    .status_i (status_i),
    .upd_i    (upd),
    .val_i    (val),
    .status_o (status_o)
  );

  // ---------------- assertions ----------------
  always_comb begin
    assert_fixed_bits_R1: assert (status_o[SB_ONE] &&
      (status_o[SB_B:SB_I] == status_i[SB_B:SB_I]))
      else $error("fixed status bits disturbed");

    if (op_i == OP_ADD_C) begin
      assert_add_sum_R2: assert ({status_o[SB_C], result_o} ==
        ({1'b0, a_i} + {1'b0, m_i} + (WIDTH+1)'(status_i[SB_C])))
        else $error("add result or carry wrong");
    end

    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) begin
      assert_logic_keeps_vc_R4: assert ((status_o[SB_V] == status_i[SB_V]) &&
        (status_o[SB_C] == status_i[SB_C]))
        else $error("logic op touched V or C");
    end

    if (op_i == OP_CMP) begin
      assert_cmp_carry_R8: assert ((status_o[SB_C] == (a_i >= m_i)) && (result_o == a_i))
        else $error("compare carry or result wrong");
    end

    if (op_i == OP_TEST) begin
      assert_test_flags_R9: assert ((status_o[SB_N] == m_i[MSB]) &&
        (status_o[SB_V] == m_i[MSB-1]) && (result_o == a_i))
        else $error("bit test flags wrong");
    end

    if (op_i > OP_TEST) begin
      assert_reserved_R10: assert ((result_o == a_i) &&
        (status_o == (status_i | 8'h20)))
        else $error("reserved code changed state");
    end

    if (op_i <= OP_DEC) begin
      assert_zero_neg_R11: assert ((status_o[SB_Z] == (result_o == '0)) &&
        (status_o[SB_N] == result_o[MSB]))
        else $error("N/Z disagree with result");
    end
  end

endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;
  localparam int N_RANDOM   = 600;

  logic       clk;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] a, m, st;
  logic [7:0] res;
  logic [7:0] st_out;

  int checks;
  int failures;
  bit finished;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] m;
    logic [7:0] s;
    logic [7:0] er;
    logic [7:0] es;
  } item_t;

  item_t q[$];

  acc_alu dut (
    .op_i     (op),
    .a_i      (a),
    .m_i      (m),
    .status_i (st),
    .result_o (res),
    .status_o (st_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0:  return "R2";
      4'd1:  return "R3";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7, 4'd8: return "R6";
      4'd9, 4'd10: return "R7";
      4'd11: return "R8";
      4'd12: return "R9";
      default: return "R10";
    endcase
  endfunction

  // reference model written from the requirements
  task automatic model(input logic [3:0] o, input logic [7:0] av, input logic [7:0] mv,
                       input logic [7:0] sv, output logic [7:0] r, output logic [7:0] so);
    logic n, v, z, c;
    logic [8:0] t;
    logic [7:0] d, bb;
    n = sv[7]; v = sv[6]; z = sv[1]; c = sv[0];
    r = av;
    case (o)
      4'd0, 4'd1: begin
        bb = (o == 4'd1) ? ~mv : mv;
        t = {1'b0, av} + {1'b0, bb} + {8'd0, sv[0]};
        r = t[7:0]; c = t[8];
        v = (av[7] == bb[7]) && (r[7] != av[7]);
      end
      4'd2: r = av & mv;
      4'd3: r = av | mv;
      4'd4: r = av ^ mv;
      4'd5: begin r = {av[6:0], 1'b0}; c = av[7]; end
      4'd6: begin r = {1'b0, av[7:1]}; c = av[0]; end
      4'd7: begin r = {av[6:0], sv[0]}; c = av[7]; end
      4'd8: begin r = {sv[0], av[7:1]}; c = av[0]; end
      4'd9:  r = av + 8'd1;
      4'd10: r = av - 8'd1;
      4'd11: begin
        d = av - mv; c = (av >= mv); n = d[7]; z = (d == 8'd0);
      end
      4'd12: begin
        z = ((av & mv) == 8'd0); n = mv[7]; v = mv[6];
      end
      default: ;
    endcase
    if (o <= 4'd10) begin
      n = r[7]; z = (r == 8'd0);
    end
    so = {n, v, 1'b1, sv[4:2], z, c};
  endtask

  task automatic drive(input logic [3:0] o, input logic [7:0] av,
                       input logic [7:0] mv, input logic [7:0] sv);
    item_t it;
    @(posedge clk);
    op = o; a = av; m = mv; st = sv;
    it.op = o; it.a = av; it.m = mv; it.s = sv;
    model(o, av, mv, sv, it.er, it.es);
    q.push_back(it);
  endtask

  // monitor: compares half a period after the driver applied a vector
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (res !== it.er || st_out !== it.es) begin
        failures++;
        $display("FAIL %s op=%0d a=%02h m=%02h s=%02h : result=%02h status=%02h expected result=%02h status=%02h",
                 req_of(it.op), it.op, it.a, it.m, it.s, res, st_out, it.er, it.es);
      end
      // R1: fixed bits checked independently of the model
      checks++;
      if (st_out[5] !== 1'b1 || st_out[4:2] !== it.s[4:2]) begin
        failures++;
        $display("FAIL R1 status=%02h expected bit5=1 bits4..2=%03b", st_out, it.s[4:2]);
      end
    end
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; finished = 0;
    rst_n = 1'b0;
    op = 4'd0; a = 8'd0; m = 8'd0; st = 8'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset-state inputs: all zero gives zero result with Z and bit5 (R1, R11)
    drive(4'd0, 8'h00, 8'h00, 8'h00);
    // R2: signed overflow, carry ripple to zero
    drive(4'd0, 8'h50, 8'h50, 8'h00);
    drive(4'd0, 8'hFF, 8'h01, 8'h00);
    drive(4'd0, 8'h80, 8'h80, 8'h1D);
    drive(4'd0, 8'h7F, 8'h00, 8'h01);
    // R3: borrow and no-borrow, overflow on subtract
    drive(4'd1, 8'h50, 8'hF0, 8'h01);
    drive(4'd1, 8'h00, 8'h01, 8'h01);
    drive(4'd1, 8'h80, 8'h01, 8'h01);
    drive(4'd1, 8'h05, 8'h05, 8'h00);
    // R4: logic ops keep V and C
    drive(4'd2, 8'hF0, 8'h0F, 8'hC3);
    drive(4'd3, 8'h80, 8'h01, 8'h41);
    drive(4'd4, 8'hAA, 8'hAA, 8'hFF);
    // R5: shifts
    drive(4'd5, 8'h81, 8'h00, 8'h40);
    drive(4'd6, 8'h01, 8'h00, 8'h80);
    drive(4'd6, 8'hFE, 8'h00, 8'h01);
    // R6: rotates through carry
    drive(4'd7, 8'h80, 8'h00, 8'h01);
    drive(4'd8, 8'h01, 8'h00, 8'h01);
    drive(4'd8, 8'h00, 8'h00, 8'h00);
    // R7: wrap-around increment/decrement
    drive(4'd9, 8'hFF, 8'h00, 8'h43);
    drive(4'd10, 8'h00, 8'h00, 8'h41);
    drive(4'd9, 8'h7F, 8'h00, 8'h00);
    // R8: compare equal, below, above
    drive(4'd11, 8'h40, 8'h40, 8'h40);
    drive(4'd11, 8'h10, 8'h20, 8'h01);
    drive(4'd11, 8'hF0, 8'h01, 8'h00);
    // R9: bit test
    drive(4'd12, 8'h0F, 8'hC0, 8'h01);
    drive(4'd12, 8'hFF, 8'h3F, 8'hC0);
    // R10: reserved codes
    drive(4'd13, 8'h12, 8'h34, 8'h00);
    drive(4'd14, 8'h56, 8'h78, 8'hDF);
    drive(4'd15, 8'h9A, 8'hBC, 8'h1C);

    // mixed patterns over all op codes and status polarities
    for (int i = 0; i < N_RANDOM; i++) begin
      drive(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 8'($urandom));
    end

    @(posedge clk);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule